// File: doc/BRIEF.md
# Timer-Paced Sine Sample Generator

This block produces a stepped sine wave as a stream of 4-bit codes for an external resistor-ladder DAC. A 16-bit counter runs freely, one count per clock, and is compared against a compare register. When the two are equal, the block takes an event. It adds the period input to the compare register, so the next event comes exactly one period later without the counter ever being reloaded. It also moves a read index one step through a fixed 32-entry sine table and raises a sticky event flag.

The flag acts as an interrupt request. Software clears it by writing a one on the acknowledge strobe. The tone frequency is the clock rate divided by 32 times the period. For example, a period of 1000 at a 1 MHz count rate gives one event per millisecond, and a period of about 71 at that rate gives a 440 Hz tone. The enable input pauses the waveform without disturbing the event timing.

Top module: `sine_tone_gen`

## Requirements
- R1: Reset is synchronous. During reset the counter goes to 0, the compare register takes the value of the period input, the table index goes to 0, the flag goes to 0 and the DAC output goes to the first table entry (8).
- R2: Once running, successive events fall exactly `periodIn` clock cycles apart. An event is the cycle in which the counter equals the compare register, and it becomes visible on the outputs one clock later.
- R3: The counter and the compare addition both wrap modulo 2^16, so the spacing of R2 also holds when the sum passes 65535.
- R4: At an enabled event the table index steps by one, and the DAC output shows the new entry on the same clock edge that sets the flag. At no other time does the DAC output change.
- R5: In index order 0..31 the table holds 8,9,11,12,13,14,14,15,15,15,14,14,13,12,11,9,8,7,5,4,3,2,2,1,1,1,2,2,3,4,5,7.
- R6: The index wraps from 31 to 0, so the 32nd event after reset shows entry 0 (8) again.
- R7: A cycle with `ackWr`=1 and `ackData`=1 clears the flag on the next edge.
- R8: A cycle with `ackWr`=1 and `ackData`=0 leaves the flag unchanged.
- R9: If an enabled event and a clearing write fall in the same cycle, the flag ends set.
- R10: While `enable` is 0, events raise no flag and the index and DAC output hold. The compare register still advances at each match, so after re-enabling, events keep their original phase.
- R11: The period input is sampled at each event. A new value first affects the spacing to the event after the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock |
| rstN | input | 1 | Synchronous reset, active low |
| periodIn | input | 16 | Counts between events |
| enable | input | 1 | Allows events to step the table and raise the flag |
| ackWr | input | 1 | Flag write strobe |
| ackData | input | 1 | Write value; 1 clears the flag |
| dacOut | output | 4 | Current sine code for the DAC |
| flagOut | output | 1 | Sticky event flag |

## Verification
The bench walks the whole table and past the index wrap, so a design that read the table one entry late or failed to return to 8 shows a wrong code on the first or the 32nd event. It drives a clearing write into the very cycle of an event, where a design that gave priority to the clear would lose the request. It also writes a zero, which a design that treated every write as a clear would wrongly honour.

A run with a period of 30000 forces the compare sum through 2^16. There, a saturating or wider adder would stretch or lose an interval. A long pause with enable low checks that no flag or step slips through, and that the phase after re-enabling stays on the original grid. A period change mid-run checks that a design which sampled the period at the wrong time shifts the next event by the wrong amount.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int DAC_W   = 4;
  localparam int TAB_LEN = 32;
  localparam int IDX_W   = $clog2(TAB_LEN);

  // strobes from control to datapath
  typedef struct packed {
    logic rearm;  // compare matched: advance compare register
    logic fire;   // enabled event: step index, refresh DAC code
    logic clear;  // flag clear request
  } toneStrobe_t;

  function automatic logic [DAC_W-1:0] sineSample(input logic [IDX_W-1:0] idx);
    logic [DAC_W-1:0] v;
    case (idx)
      5'd0:  v = 4'd8;   5'd1:  v = 4'd9;   5'd2:  v = 4'd11;  5'd3:  v = 4'd12;
      5'd4:  v = 4'd13;  5'd5:  v = 4'd14;  5'd6:  v = 4'd14;  5'd7:  v = 4'd15;
      5'd8:  v = 4'd15;  5'd9:  v = 4'd15;  5'd10: v = 4'd14;  5'd11: v = 4'd14;
      5'd12: v = 4'd13;  5'd13: v = 4'd12;  5'd14: v = 4'd11;  5'd15: v = 4'd9;
      5'd16: v = 4'd8;   5'd17: v = 4'd7;   5'd18: v = 4'd5;   5'd19: v = 4'd4;
      5'd20: v = 4'd3;   5'd21: v = 4'd2;   5'd22: v = 4'd2;   5'd23: v = 4'd1;
      5'd24: v = 4'd1;   5'd25: v = 4'd1;   5'd26: v = 4'd2;   5'd27: v = 4'd2;
      5'd28: v = 4'd3;   5'd29: v = 4'd4;   5'd30: v = 4'd5;   default: v = 4'd7;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/tone_control.sv
module tone_control
  import tone_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        hit,
  input  logic        ackWr,
  input  logic        ackData,
  output toneStrobe_t strobes,
  output logic        flagOut
);
  logic flagQ;

  always_comb begin
    strobes.rearm = hit;
    strobes.fire  = hit & enable;
    strobes.clear = ackWr & ackData;
  end

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)              flagQ <= 1'b0;
    else if (strobes.fire)  flagQ <= 1'b1;
    else if (strobes.clear) flagQ <= 1'b0;
  end

  assign flagOut = flagQ;
endmodule

// File: rtl/tone_datapath.sv
module tone_datapath
  import tone_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodIn,
  input  toneStrobe_t      strobes,
  output logic             hit,
  output logic [DAC_W-1:0] dacOut
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cmpQ;
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] idxNext;
  logic [DAC_W-1:0] dacQ;

  assign hit     = (cntQ == cmpQ);
  assign idxNext = idxQ + 1'b1;  // natural wrap 31 -> 0

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      cmpQ <= periodIn;  // counter restarts at zero, so zero plus period
      idxQ <= '0;
      dacQ <= sineSample('0);
    end else begin
      cntQ <= cntQ + 1'b1;
      if (strobes.rearm) cmpQ <= cmpQ + periodIn;
      if (strobes.fire) begin
        idxQ <= idxNext;
        dacQ <= sineSample(idxNext);
      end
    end
  end

  assign dacOut = dacQ;
endmodule

// File: rtl/sine_tone_gen.sv
module sine_tone_gen
  import tone_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodIn,
  input  logic             enable,
  input  logic             ackWr,
  input  logic             ackData,
  output logic [DAC_W-1:0] dacOut,
  output logic             flagOut
);
  toneStrobe_t ctrlStrobes;
  logic        hitSig;

  tone_control u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .hit(hitSig),
    .ackWr(ackWr), .ackData(ackData), .strobes(ctrlStrobes), .flagOut(flagOut)
  );

  tone_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .strobes(ctrlStrobes),
    .hit(hitSig), .dacOut(dacOut)
  );
endmodule

// File: rtl/sine_tone_gen_chk.sv
module sine_tone_gen_chk
  import tone_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             ackWr,
  input logic             ackData,
  input logic [DAC_W-1:0] dacOut,
  input logic             flagOut,
  input toneStrobe_t      strobes
);
  // R10
  idle_dac_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(dacOut));
  // R10
  idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !$rose(flagOut));
  // R7
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackWr && ackData && !strobes.fire) |=> !flagOut);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |=> flagOut);
  // R8
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagOut && ackWr && !ackData) |=> flagOut);
  // R4
  dac_moves_on_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacOut) |-> $past(strobes.fire));
endmodule

bind sine_tone_gen sine_tone_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .ackWr(ackWr), .ackData(ackData),
  .dacOut(dacOut), .flagOut(flagOut), .strobes(ctrlStrobes)
);

// File: tb/tb_sine_tone_gen.sv
module tb_sine_tone_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] periodIn = 16'd6;
  logic        enable = 1'b1;
  logic        ackWr = 1'b0;
  logic        ackData = 1'b0;
  logic [3:0]  dacOut;
  logic        flagOut;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  localparam logic [3:0] EXP_WAVE [32] = '{
    4'd8, 4'd9, 4'd11, 4'd12, 4'd13, 4'd14, 4'd14, 4'd15,
    4'd15, 4'd15, 4'd14, 4'd14, 4'd13, 4'd12, 4'd11, 4'd9,
    4'd8, 4'd7, 4'd5, 4'd4, 4'd3, 4'd2, 4'd2, 4'd1,
    4'd1, 4'd1, 4'd2, 4'd2, 4'd3, 4'd4, 4'd5, 4'd7};

  sine_tone_gen dut (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .enable(enable),
    .ackWr(ackWr), .ackData(ackData), .dacOut(dacOut), .flagOut(flagOut)
  );

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    total++; fails++;
    $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
    finishRun();
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [15:0] p);
    rstN = 1'b0; periodIn = p; enable = 1'b1; ackWr = 1'b0; ackData = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // wait at negedges until the flag shows; return cycle stamp
  task automatic waitFlag(output int t);
    while (!flagOut) @(negedge clk);
    t = cyc;
  endtask

  task automatic ackNow();
    ackWr = 1'b1; ackData = 1'b1;
    @(negedge clk);
    ackWr = 1'b0; ackData = 1'b0;
  endtask

  initial begin
    int tPrev, tNow, held;
    // R1: state while in reset
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 dac reset", dacOut, 8);
    chk("R1 flag reset", flagOut, 0);
    doReset(16'd6);

    // first event, then walk the table through the wrap (R2 R4 R5 R6 R7)
    waitFlag(tPrev);
    chk("R4 first code", dacOut, EXP_WAVE[1]);
    ackNow();
    chk("R7 flag cleared", flagOut, 0);
    for (int k = 2; k <= 33; k++) begin
      waitFlag(tNow);
      chk("R2 spacing", tNow - tPrev, 6);
      chk((k == 32) ? "R6 index wrap" : "R5 table entry", dacOut, EXP_WAVE[k % 32]);
      tPrev = tNow;
      ackNow();
    end

    // R8: writing zero keeps the flag
    waitFlag(tNow);
    chk("R2 spacing", tNow - tPrev, 6);
    tPrev = tNow;
    ackWr = 1'b1; ackData = 1'b0;
    @(negedge clk);
    ackWr = 1'b0;
    chk("R8 zero write", flagOut, 1);
    ackNow();
    chk("R7 flag cleared", flagOut, 0);

    // R9: clear in the event cycle; flag must stay set
    while (cyc < tPrev + 5) @(negedge clk);
    ackWr = 1'b1; ackData = 1'b1;
    @(negedge clk);
    ackWr = 1'b0; ackData = 1'b0;
    chk("R9 set over clear", flagOut, 1);
    chk("R9 event cycle", cyc - tPrev, 6);
    chk("R4 step at event", dacOut, EXP_WAVE[3]);
    tPrev = cyc;

    // R11: new period first affects the interval after next
    periodIn = 16'd10;
    ackNow();
    waitFlag(tNow);
    chk("R11 old period kept", tNow - tPrev, 6);
    tPrev = tNow;
    ackNow();
    waitFlag(tNow);
    chk("R11 new period", tNow - tPrev, 10);
    tPrev = tNow;
    ackNow();

    // R10: pause for 25 cycles, then resume on the same grid
    held = dacOut;
    enable = 1'b0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (flagOut || dacOut != held) chk("R10 idle hold", {flagOut, dacOut}, held);
    end
    chk("R10 idle flag", flagOut, 0);
    chk("R10 idle dac", dacOut, held);
    enable = 1'b1;
    waitFlag(tNow);
    chk("R10 phase kept", tNow - tPrev, 30);
    chk("R10 single step", dacOut, EXP_WAVE[6]);

    // R3: compare sum wraps past 2^16
    doReset(16'd30000);
    waitFlag(tPrev);
    ackNow();
    for (int k = 0; k < 2; k++) begin
      waitFlag(tNow);
      chk("R3 wrap spacing", tNow - tPrev, 30000);
      tPrev = tNow;
      ackNow();
    end
    chk("R3 code after wrap", dacOut, EXP_WAVE[3]);

    finishRun();
  end
endmodule